// File: doc/BRIEF.md
# I2C Transaction Sequencer

This block sits between a register port and a byte-level I2C bus engine. Software programs a target address byte, a byte count, a transfer count and a few control bits, then writes a launch word. The sequencer walks the engine through each transfer: it issues START, the address byte and the data bytes, followed by a STOP or a repeated START. Each command waits for the engine's completion pulse. Write data is pulled from an outside byte source, and each received byte is pushed out with a strobe.

A combined write-then-read mode runs both phases from one launch. The two byte counts share one length register, and the address byte's direction bit flips for the read phase. An auto-restart mode stops after every transfer and raises a per-transfer flag, then waits for software to trigger the next one. Five status flags with write-one-to-clear behaviour are gated by a mask into a single interrupt line. Errors always come before the completion flag. After a NACK the sequencer sends a STOP and then completes. After a lost arbitration it completes at once and drives nothing further on the bus.

Top module: `i2c_txn_seq`

## Requirements
- R1: After reset the status register reads 0, `cmd_valid` is low and `irq` is low.
- R2: Offset 1 holds the address byte, whose bit 0 selects read (1) or write (0). Writing offset 6 with bit 0 set, while idle, launches a sequence. A single transfer of N bytes issues START, then WRITE carrying the address byte, then N data commands, then STOP. Command codes are 1=START, 2=WRITE, 3=READ, 4=RSTART, 5=STOP. A READ raises `cmd_last` on its final byte only.
- R3: Offset 5 holds the transfer count. Between transfers, control (offset 0) bit 1 set gives RSTART, and clear gives STOP followed by START. Each transfer moves the low-byte length.
- R4: Control bit 4 selects combined mode. It writes the low byte of offset 4 as a byte count, with the address bit 0 forced to 0. It then sends RSTART and reads the high-byte count with address bit 0 forced to 1. The transfer count is taken as 2.
- R5: Status is at offset 3. Bit 0 means complete, bit 1 ACK error, bit 2 NACK in high-speed mode, bit 3 arbitration lost and bit 4 transfer done under auto-restart. Writing 1 to a bit clears it. A normal sequence leaves 0x01.
- R6: `irq` is high exactly when some status bit is set and its mask bit (offset 2) is set.
- R7: A NACK on the address byte or a written byte sets bit 1, or bit 2 when control bit 2 is set. The sequencer then issues STOP and only afterwards sets complete.
- R8: Lost arbitration sets bit 3, issues no further command and sets complete on the next cycle.
- R9: A launch with bit 14 set runs in auto-restart mode. After each transfer, bit 4 is set. If the triggering write had bit 15 set, the sequencer waits with no command pending. A further write with bit 0 resumes with RSTART. Bit 15 clear ends the run with STOP and complete.
- R10: A launch with a zero low length is ignored and nothing starts. The same holds for a zero high length in combined mode, and for a zero transfer count outside auto-restart.
- R11: A launch written while a sequence is running has no effect.
- R12: `cmd_valid` and `cmd_op` hold steady from the issue of a command until `eng_done`.
- R13: `tx_pop` pulses once per acknowledged written data byte. `rx_push` pulses once per read byte, with `rx_byte` carrying the engine's data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| irq | output | 1 | Masked status interrupt |
| cmd_valid | output | 1 | Command pending to byte engine |
| cmd_op | output | 3 | Command code |
| cmd_wdata | output | 8 | Byte to transmit for WRITE |
| cmd_last | output | 1 | Final byte of a read phase |
| eng_done | input | 1 | Engine finished current command |
| eng_ack_ok | input | 1 | Byte was acknowledged |
| eng_arb_lost | input | 1 | Arbitration lost during command |
| eng_rdata | input | 8 | Received byte |
| tx_byte | input | 8 | Next write data byte |
| tx_pop | output | 1 | Write byte consumed |
| rx_push | output | 1 | Read byte available |
| rx_byte | output | 8 | Read byte |

## Verification
The most difficult case to reach is an error that arrives in the middle of a sequence, followed by the strict order of error flag, optional STOP and complete flag. The bench's engine model refuses or loses arbitration on a chosen command index. The bench polls the status register every cycle and records the first cycle with an error flag and the first cycle with completion. The paused auto-restart state is also reached on purpose: the bench holds back the resuming trigger, checks that no command appears, then triggers the remaining transfer.

// File: rtl/i2c_txn_seq_pkg.sv
`timescale 1ns/1ps
package i2c_txn_seq_pkg;
  localparam int NSTAT = 5;
  // status bit positions
  localparam int SB_DONE   = 0;
  localparam int SB_NACK   = 1;
  localparam int SB_HSNACK = 2;
  localparam int SB_ARB    = 3;
  localparam int SB_RSDONE = 4;
  // control bit positions
  localparam int CB_RS  = 1;
  localparam int CB_HS  = 2;
  localparam int CB_DIR = 4;
  // launch word bit positions
  localparam int LB_GO   = 0;
  localparam int LB_AUTO = 14;
  localparam int LB_CONT = 15;
  // register offsets
  localparam int RA_CTRL   = 0;
  localparam int RA_TARGET = 1;
  localparam int RA_MASK   = 2;
  localparam int RA_STAT   = 3;
  localparam int RA_LEN    = 4;
  localparam int RA_COUNT  = 5;
  localparam int RA_LAUNCH = 6;
  // engine command codes
  localparam logic [2:0] OP_NONE   = 3'd0;
  localparam logic [2:0] OP_START  = 3'd1;
  localparam logic [2:0] OP_WRITE  = 3'd2;
  localparam logic [2:0] OP_READ   = 3'd3;
  localparam logic [2:0] OP_RSTART = 3'd4;
  localparam logic [2:0] OP_STOP   = 3'd5;

  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_ADDR, ST_DATA, ST_RSTART,
    ST_GSTOP, ST_ESTOP, ST_FINISH, ST_PAUSE
  } seq_state_e;
endpackage

// File: rtl/i2c_txn_seq_rstsync.sv
`timescale 1ns/1ps
module i2c_txn_seq_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/i2c_txn_seq_regs.sv
`timescale 1ns/1ps
module i2c_txn_seq_regs
  import i2c_txn_seq_pkg::*;
#(
  parameter int REG_W  = 16,
  parameter int ADDR_W = 3,
  parameter int LEN_W  = 8,
  parameter int CNT_W  = 8,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic [NSTAT-1:0]  stat_set_i,
  output logic              ctrl_rs_o,
  output logic              ctrl_hs_o,
  output logic              ctrl_dir_o,
  output logic [BYTE_W-1:0] target_o,
  output logic [NSTAT-1:0]  mask_o,
  output logic [LEN_W-1:0]  len_lo_o,
  output logic [LEN_W-1:0]  len_hi_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [NSTAT-1:0]  stat_o,
  output logic [REG_W-1:0]  rdata_o,
  output logic              irq_o
);
  logic wr_ctrl, wr_tgt, wr_mask, wr_stat, wr_len, wr_cnt;
  logic [NSTAT-1:0] stat_q, stat_d, stat_clr;
  logic [2:0]       ctrl_q;

  always_comb begin
    wr_ctrl  = wr_i && (addr_i == ADDR_W'(RA_CTRL));
    wr_tgt   = wr_i && (addr_i == ADDR_W'(RA_TARGET));
    wr_mask  = wr_i && (addr_i == ADDR_W'(RA_MASK));
    wr_stat  = wr_i && (addr_i == ADDR_W'(RA_STAT));
    wr_len   = wr_i && (addr_i == ADDR_W'(RA_LEN));
    wr_cnt   = wr_i && (addr_i == ADDR_W'(RA_COUNT));
    stat_clr = wr_stat ? wdata_i[NSTAT-1:0] : '0;
    // a set event in the same cycle wins over a clear
    stat_d   = (stat_q & ~stat_clr) | stat_set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      target_o <= '0;
      mask_o   <= '0;
      len_lo_o <= '0;
      len_hi_o <= '0;
      cnt_o    <= '0;
    end else begin
      if (wr_ctrl) ctrl_q   <= {wdata_i[CB_DIR], wdata_i[CB_HS], wdata_i[CB_RS]};
      if (wr_tgt)  target_o <= wdata_i[BYTE_W-1:0];
      if (wr_mask) mask_o   <= wdata_i[NSTAT-1:0];
      if (wr_len) begin
        len_lo_o <= wdata_i[LEN_W-1:0];
        len_hi_o <= wdata_i[2*LEN_W-1:LEN_W];
      end
      if (wr_cnt)  cnt_o    <= wdata_i[CNT_W-1:0];
    end
  end

  assign ctrl_rs_o  = ctrl_q[0];
  assign ctrl_hs_o  = ctrl_q[1];
  assign ctrl_dir_o = ctrl_q[2];
  assign stat_o     = stat_q;
  assign irq_o      = |(stat_q & mask_o);

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(RA_CTRL): begin
        rdata_o[CB_RS]  = ctrl_q[0];
        rdata_o[CB_HS]  = ctrl_q[1];
        rdata_o[CB_DIR] = ctrl_q[2];
      end
      ADDR_W'(RA_TARGET): rdata_o[BYTE_W-1:0]  = target_o;
      ADDR_W'(RA_MASK):   rdata_o[NSTAT-1:0]   = mask_o;
      ADDR_W'(RA_STAT):   rdata_o[NSTAT-1:0]   = stat_q;
      ADDR_W'(RA_LEN):    rdata_o[2*LEN_W-1:0] = {len_hi_o, len_lo_o};
      ADDR_W'(RA_COUNT):  rdata_o[CNT_W-1:0]   = cnt_o;
      default:            rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/i2c_txn_seq_fsm.sv
`timescale 1ns/1ps
module i2c_txn_seq_fsm
  import i2c_txn_seq_pkg::*;
#(
  parameter int LEN_W  = 8,
  parameter int CNT_W  = 8,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic              auto_i,
  input  logic              cont_i,
  input  logic              ctrl_rs_i,
  input  logic              ctrl_hs_i,
  input  logic              ctrl_dir_i,
  input  logic [BYTE_W-1:0] target_i,
  input  logic [LEN_W-1:0]  len_lo_i,
  input  logic [LEN_W-1:0]  len_hi_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              eng_done_i,
  input  logic              eng_ack_ok_i,
  input  logic              eng_arb_lost_i,
  input  logic [BYTE_W-1:0] eng_rdata_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  output logic              cmd_valid_o,
  output logic [2:0]        cmd_op_o,
  output logic [BYTE_W-1:0] cmd_wdata_o,
  output logic              cmd_last_o,
  output logic              tx_pop_o,
  output logic              rx_push_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic [NSTAT-1:0]  stat_set_o
);
  seq_state_e        state_q, state_d;
  logic [CNT_W-1:0]  xfer_q, xfer_d;
  logic [LEN_W-1:0]  byte_q, byte_d;
  logic              auto_q, auto_d, cont_q, cont_d, comb_q, comb_d;
  logic              pop_d, push_d, push_q, pop_q;
  logic [BYTE_W-1:0] rxb_q;

  logic              second, cur_rd, last_byte, last_xfer, launch_ok, comb_req;
  logic [LEN_W-1:0]  cur_len;
  logic [CNT_W-1:0]  total;
  logic [NSTAT-1:0]  nack_flag;

  always_comb begin
    second    = (xfer_q != '0);
    cur_rd    = comb_q ? second : target_i[0];
    cur_len   = (comb_q && second) ? len_hi_i : len_lo_i;
    total     = comb_q ? CNT_W'(2) : cnt_i;
    last_byte = (byte_q == cur_len - 1'b1);
    last_xfer = (xfer_q == total - 1'b1);
    nack_flag = '0;
    nack_flag[ctrl_hs_i ? SB_HSNACK : SB_NACK] = 1'b1;
    comb_req  = ctrl_dir_i && !auto_i;
    launch_ok = (len_lo_i != '0) && (!comb_req || (len_hi_i != '0)) &&
                (auto_i || (cnt_i != '0));
  end

  // next-state logic
  always_comb begin
    state_d    = state_q;
    xfer_d     = xfer_q;
    byte_d     = byte_q;
    auto_d     = auto_q;
    cont_d     = cont_q;
    comb_d     = comb_q;
    stat_set_o = '0;
    case (state_q)
      ST_IDLE: begin
        if (go_i && launch_ok) begin
          state_d = ST_START;
          xfer_d  = '0;
          byte_d  = '0;
          auto_d  = auto_i;
          cont_d  = cont_i;
          comb_d  = comb_req;
        end
      end
      ST_PAUSE: begin
        if (go_i) begin
          cont_d  = cont_i;
          state_d = ST_RSTART;
        end
      end
      ST_FINISH: begin
        stat_set_o[SB_DONE] = 1'b1;
        state_d = ST_IDLE;
      end
      default: begin
        if (eng_done_i) begin
          if (eng_arb_lost_i) begin
            stat_set_o[SB_ARB] = 1'b1;
            state_d = ST_FINISH;
          end else begin
            case (state_q)
              ST_START, ST_RSTART: state_d = ST_ADDR;
              ST_ADDR: begin
                if (!eng_ack_ok_i) begin
                  stat_set_o = nack_flag;
                  state_d    = ST_ESTOP;
                end else begin
                  byte_d  = '0;
                  state_d = ST_DATA;
                end
              end
              ST_DATA: begin
                if (!cur_rd && !eng_ack_ok_i) begin
                  stat_set_o = nack_flag;
                  state_d    = ST_ESTOP;
                end else if (last_byte) begin
                  if (auto_q) begin
                    stat_set_o[SB_RSDONE] = 1'b1;
                    state_d = cont_q ? ST_PAUSE : ST_ESTOP;
                  end else if (last_xfer) begin
                    state_d = ST_ESTOP;
                  end else begin
                    xfer_d  = xfer_q + 1'b1;
                    state_d = (ctrl_rs_i || comb_q) ? ST_RSTART : ST_GSTOP;
                  end
                end else begin
                  byte_d = byte_q + 1'b1;
                end
              end
              ST_GSTOP: state_d = ST_START;
              ST_ESTOP: state_d = ST_FINISH;
              default:  state_d = ST_IDLE;
            endcase
          end
        end
      end
    endcase
  end

  always_comb begin
    pop_d  = eng_done_i && (state_q == ST_DATA) && !cur_rd &&
             eng_ack_ok_i && !eng_arb_lost_i;
    push_d = eng_done_i && (state_q == ST_DATA) && cur_rd && !eng_arb_lost_i;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      xfer_q  <= '0;
      byte_q  <= '0;
      auto_q  <= 1'b0;
      cont_q  <= 1'b0;
      comb_q  <= 1'b0;
      pop_q   <= 1'b0;
      push_q  <= 1'b0;
      rxb_q   <= '0;
    end else begin
      state_q <= state_d;
      xfer_q  <= xfer_d;
      byte_q  <= byte_d;
      auto_q  <= auto_d;
      cont_q  <= cont_d;
      comb_q  <= comb_d;
      pop_q   <= pop_d;
      push_q  <= push_d;
      if (push_d) rxb_q <= eng_rdata_i;
    end
  end

  // command outputs
  always_comb begin
    cmd_valid_o = 1'b1;
    cmd_wdata_o = '0;
    cmd_last_o  = 1'b0;
    case (state_q)
      ST_START:  cmd_op_o = OP_START;
      ST_RSTART: cmd_op_o = OP_RSTART;
      ST_GSTOP, ST_ESTOP: cmd_op_o = OP_STOP;
      ST_ADDR: begin
        cmd_op_o    = OP_WRITE;
        cmd_wdata_o = comb_q ? {target_i[BYTE_W-1:1], second} : target_i;
      end
      ST_DATA: begin
        cmd_op_o    = cur_rd ? OP_READ : OP_WRITE;
        cmd_wdata_o = cur_rd ? '0 : tx_byte_i;
        cmd_last_o  = cur_rd && last_byte;
      end
      default: begin
        cmd_op_o    = OP_NONE;
        cmd_valid_o = 1'b0;
      end
    endcase
  end

  assign tx_pop_o  = pop_q;
  assign rx_push_o = push_q;
  assign rx_byte_o = rxb_q;
endmodule

// File: rtl/i2c_txn_seq.sv
`timescale 1ns/1ps
module i2c_txn_seq
  import i2c_txn_seq_pkg::*;
#(
  parameter int REG_W  = 16,
  parameter int ADDR_W = 3,
  parameter int LEN_W  = 8,
  parameter int CNT_W  = 8,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq,
  output logic              cmd_valid,
  output logic [2:0]        cmd_op,
  output logic [BYTE_W-1:0] cmd_wdata,
  output logic              cmd_last,
  input  logic              eng_done,
  input  logic              eng_ack_ok,
  input  logic              eng_arb_lost,
  input  logic [BYTE_W-1:0] eng_rdata,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [BYTE_W-1:0] rx_byte
);
  logic              srst_n, go;
  logic              rs_w, hs_w, dir_w;
  logic [BYTE_W-1:0] target_w;
  logic [NSTAT-1:0]  mask_w, stat_w, set_w;
  logic [LEN_W-1:0]  lo_w, hi_w;
  logic [CNT_W-1:0]  cnt_w;

  assign go = reg_wr && (reg_addr == ADDR_W'(RA_LAUNCH)) && reg_wdata[LB_GO];

  i2c_txn_seq_rstsync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(srst_n)
  );

  i2c_txn_seq_regs #(
    .REG_W(REG_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W), .BYTE_W(BYTE_W)
  ) u_regs (
    .clk(clk), .rst_n(srst_n), .wr_i(reg_wr), .addr_i(reg_addr),
    .wdata_i(reg_wdata), .stat_set_i(set_w),
    .ctrl_rs_o(rs_w), .ctrl_hs_o(hs_w), .ctrl_dir_o(dir_w),
    .target_o(target_w), .mask_o(mask_w), .len_lo_o(lo_w), .len_hi_o(hi_w),
    .cnt_o(cnt_w), .stat_o(stat_w), .rdata_o(reg_rdata), .irq_o(irq)
  );

  i2c_txn_seq_fsm #(.LEN_W(LEN_W), .CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_fsm (
    .clk(clk), .rst_n(srst_n), .go_i(go),
    .auto_i(reg_wdata[LB_AUTO]), .cont_i(reg_wdata[LB_CONT]),
    .ctrl_rs_i(rs_w), .ctrl_hs_i(hs_w), .ctrl_dir_i(dir_w),
    .target_i(target_w), .len_lo_i(lo_w), .len_hi_i(hi_w), .cnt_i(cnt_w),
    .eng_done_i(eng_done), .eng_ack_ok_i(eng_ack_ok),
    .eng_arb_lost_i(eng_arb_lost), .eng_rdata_i(eng_rdata),
    .tx_byte_i(tx_byte), .cmd_valid_o(cmd_valid), .cmd_op_o(cmd_op),
    .cmd_wdata_o(cmd_wdata), .cmd_last_o(cmd_last), .tx_pop_o(tx_pop),
    .rx_push_o(rx_push), .rx_byte_o(rx_byte), .stat_set_o(set_w)
  );
endmodule

// File: rtl/i2c_txn_seq_chk.sv
`timescale 1ns/1ps
module i2c_txn_seq_chk
  import i2c_txn_seq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [2:0]       cmd_op,
  input logic             eng_done,
  input logic             eng_ack_ok,
  input logic             eng_arb_lost,
  input logic             tx_pop,
  input logic             rx_push,
  input logic             irq,
  input logic [NSTAT-1:0] mask,
  input logic [NSTAT-1:0] stat
);
  p_cmd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !eng_done |=> cmd_valid && $stable(cmd_op));

  p_nack_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd_op == OP_WRITE) && eng_done && !eng_ack_ok && !eng_arb_lost
    |=> cmd_valid && (cmd_op == OP_STOP));

  p_arb_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[SB_ARB]) |=> stat[SB_DONE] && !cmd_valid);

  p_pop_after_done_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pop || rx_push) |-> $past(eng_done));

  p_one_strobe_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_pop, rx_push}));

  p_masked_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq);
endmodule

bind i2c_txn_seq i2c_txn_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .eng_done(eng_done), .eng_ack_ok(eng_ack_ok), .eng_arb_lost(eng_arb_lost),
  .tx_pop(tx_pop), .rx_push(rx_push), .irq(irq), .mask(mask_w), .stat(stat_w)
);

// File: tb/i2c_txn_seq_tb.sv
`timescale 1ns/1ps
module i2c_txn_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic        irq, cmd_valid, cmd_last, tx_pop, rx_push;
  logic [2:0]  cmd_op;
  logic [7:0]  cmd_wdata, rx_byte;
  logic        eng_done = 1'b0, eng_ack_ok = 1'b1, eng_arb_lost = 1'b0;
  logic [7:0]  eng_rdata = 8'd0;
  logic [7:0]  tx_byte;

  always #2.5 clk = ~clk;

  i2c_txn_seq u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_wdata(cmd_wdata),
    .cmd_last(cmd_last), .eng_done(eng_done), .eng_ack_ok(eng_ack_ok),
    .eng_arb_lost(eng_arb_lost), .eng_rdata(eng_rdata), .tx_byte(tx_byte),
    .tx_pop(tx_pop), .rx_push(rx_push), .rx_byte(rx_byte)
  );

  int checks = 0, errors = 0, cyc = 0;
  // engine model state and log
  int ncmd = 0, dly = 0, nack_at = 999, arb_at = 999, hs_err = 0;
  int logn = 0, tx_cnt = 0, rx_n = 0;
  logic [2:0] held_op = 3'd0;
  logic [2:0] log_op [64];
  logic [7:0] log_dat[64];
  logic [2:0] exp_op [64];
  logic [7:0] exp_dat[64];
  int exp_n = 0, kx = 0;

  assign tx_byte = tx_cnt[7:0];

  always @(negedge clk) begin
    if (tx_pop) tx_cnt = tx_cnt + 1;
    if (rx_push) rx_n = rx_n + 1;
    if (eng_done) begin
      eng_done = 1'b0; eng_ack_ok = 1'b1; eng_arb_lost = 1'b0;
    end else if (cmd_valid) begin
      if (dly == 0) held_op = cmd_op;
      else if (held_op != cmd_op) hs_err = hs_err + 1;
      if (dly == 1) begin
        if (logn < 64) begin
          log_op[logn]  = cmd_op;
          log_dat[logn] = (cmd_op == 3'd2) ? cmd_wdata :
                          (cmd_op == 3'd3) ? {7'd0, cmd_last} : 8'd0;
        end
        logn = logn + 1;
        eng_ack_ok   = (ncmd != nack_at);
        eng_arb_lost = (ncmd == arb_at);
        eng_rdata    = 8'h5A ^ ncmd[7:0];
        eng_done     = 1'b1;
        ncmd = ncmd + 1;
        dly  = 0;
      end else dly = dly + 1;
    end
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc == 150000) begin
      checks = checks + 1; errors = errors + 1;
      $display("FAIL watchdog expired: actual %0d cycles expected fewer", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic clear_run();
    @(negedge clk);
    #1;
    ncmd = 0; logn = 0; tx_cnt = 0; rx_n = 0; nack_at = 999; arb_at = 999;
    exp_n = 0; kx = 0;
  endtask

  task automatic push(input logic [2:0] op, input logic [7:0] d);
    exp_op[exp_n] = op; exp_dat[exp_n] = d; exp_n = exp_n + 1;
  endtask

  task automatic push_data(input bit rdir, input int len);
    for (int j = 0; j < len; j++) begin
      if (rdir) push(3'd3, (j == len - 1) ? 8'd1 : 8'd0);
      else begin push(3'd2, kx[7:0]); kx = kx + 1; end
    end
  endtask

  task automatic build_plain(input bit rdir, input bit rs, input logic [7:0] tgt,
                             input int len, input int cnt);
    for (int t = 0; t < cnt; t++) begin
      if (t == 0) push(3'd1, 8'd0);
      else if (rs) push(3'd4, 8'd0);
      else begin push(3'd5, 8'd0); push(3'd1, 8'd0); end
      push(3'd2, tgt);
      push_data(rdir, len);
    end
    push(3'd5, 8'd0);
  endtask

  task automatic cmp_seq(input string what);
    int bad = -1;
    if (logn != exp_n) begin
      check(0, {what, " command count"}, logn, exp_n);
    end else begin
      for (int i = 0; i < exp_n; i++)
        if (bad < 0 && (log_op[i] != exp_op[i] || log_dat[i] != exp_dat[i])) bad = i;
      if (bad >= 0)
        check(0, {what, " command op/data"}, {log_op[bad], log_dat[bad]},
              {exp_op[bad], exp_dat[bad]});
      else check(1, what, 0, 0);
    end
  endtask

  task automatic wait_done(output int t_err, output int t_done);
    logic [15:0] s;
    t_err = -1; t_done = -1;
    for (int i = 0; i < 3000; i++) begin
      rd(3'd3, s);
      if (t_err < 0 && (s & 16'h000E) != 0) t_err = i;
      if (s[0]) begin t_done = i; break; end
    end
    if (t_done < 0) check(0, "completion timeout", 0, 1);
  endtask

  task automatic wait_bit4();
    logic [15:0] s;
    for (int i = 0; i < 3000; i++) begin
      rd(3'd3, s);
      if (s[4]) break;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [15:0] s;
    int te, td;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    rd(3'd3, s);
    check(s == 16'd0, "R1 status after reset", s, 0);
    check(cmd_valid == 1'b0, "R1 cmd_valid after reset", cmd_valid, 0);
    check(irq == 1'b0, "R1 irq after reset", irq, 0);

    // R2 R3 R13 sweep of plain transfers
    for (int rdir = 0; rdir < 2; rdir++)
      for (int rs = 0; rs < 2; rs++)
        for (int len = 1; len <= 3; len++)
          for (int cnt = 1; cnt <= 3; cnt++) begin
            wr(3'd0, rs[0] ? 16'h0002 : 16'h0000);
            wr(3'd1, 16'h00A4 | 16'(rdir));
            wr(3'd4, 16'(len));
            wr(3'd5, 16'(cnt));
            clear_run();
            build_plain(rdir[0], rs[0], 8'hA4 | 8'(rdir), len, cnt);
            wr(3'd6, 16'h0001);
            wait_done(te, td);
            cmp_seq("R2 R3 R12 sequence");
            rd(3'd3, s);
            check(s == 16'h0001, "R5 status after run", s, 1);
            check(rx_n == (rdir ? len * cnt : 0), "R13 rx pushes", rx_n, rdir ? len * cnt : 0);
            check(tx_cnt == (rdir ? 0 : len * cnt), "R13 tx pops", tx_cnt, rdir ? 0 : len * cnt);
            wr(3'd3, 16'h001F);
            rd(3'd3, s);
            check(s == 16'd0, "R5 w1c clear", s, 0);
          end

    // R4 combined write-then-read
    for (int lo = 1; lo <= 3; lo++)
      for (int hi = 1; hi <= 3; hi++) begin
        wr(3'd0, 16'h0010);
        wr(3'd1, 16'h00A5);
        wr(3'd4, 16'((hi << 8) | lo));
        wr(3'd5, 16'd2);
        clear_run();
        push(3'd1, 8'd0); push(3'd2, 8'hA4); push_data(1'b0, lo);
        push(3'd4, 8'd0); push(3'd2, 8'hA5); push_data(1'b1, hi); push(3'd5, 8'd0);
        wr(3'd6, 16'h0001);
        wait_done(te, td);
        cmp_seq("R4 combined sequence");
        check(tx_cnt == lo && rx_n == hi, "R4 R13 phase byte counts", tx_cnt * 16 + rx_n, lo * 16 + hi);
        wr(3'd3, 16'h001F);
      end

    // R6 interrupt masking, R5 single-bit clear
    wr(3'd0, 16'h0000); wr(3'd1, 16'h00A4); wr(3'd4, 16'd1); wr(3'd5, 16'd1);
    clear_run(); wr(3'd6, 16'h0001); wait_done(te, td);
    wr(3'd2, 16'h0000); idle(1); #1;
    check(irq == 1'b0, "R6 irq masked off", irq, 0);
    wr(3'd2, 16'h001E); idle(1); #1;
    check(irq == 1'b0, "R6 irq other bits masked", irq, 0);
    wr(3'd2, 16'h0001); idle(1); #1;
    check(irq == 1'b1, "R6 irq unmasked", irq, 1);
    wr(3'd3, 16'h0002); rd(3'd3, s);
    check(s == 16'h0001, "R5 clear of unset bit keeps others", s, 1);
    wr(3'd3, 16'h0001); idle(1); #1;
    check(irq == 1'b0, "R6 irq after clear", irq, 0);
    wr(3'd2, 16'h0000);

    // R7 NACK on address byte
    wr(3'd4, 16'd3);
    clear_run(); nack_at = 1;
    push(3'd1, 8'd0); push(3'd2, 8'hA4); push(3'd5, 8'd0);
    wr(3'd6, 16'h0001); wait_done(te, td);
    cmp_seq("R7 nack address sequence");
    rd(3'd3, s);
    check(s == 16'h0003, "R7 status after nack", s, 3);
    check(te >= 0 && te < td, "R7 error before complete", te, td);
    wr(3'd3, 16'h001F);

    // R7 NACK on data in high-speed mode
    wr(3'd0, 16'h0004);
    clear_run(); nack_at = 2;
    push(3'd1, 8'd0); push(3'd2, 8'hA4); push(3'd2, 8'h00); push(3'd5, 8'd0);
    wr(3'd6, 16'h0001); wait_done(te, td);
    cmp_seq("R7 nack data sequence");
    rd(3'd3, s);
    check(s == 16'h0005, "R7 hs nack status", s, 5);
    check(tx_cnt == 0, "R13 refused byte not popped", tx_cnt, 0);
    wr(3'd3, 16'h001F);
    wr(3'd0, 16'h0000);

    // R8 arbitration lost
    clear_run(); arb_at = 3;
    push(3'd1, 8'd0); push(3'd2, 8'hA4); push(3'd2, 8'h00); push(3'd2, 8'h01);
    wr(3'd6, 16'h0001); wait_done(te, td);
    idle(10);
    cmp_seq("R8 arb sequence without stop");
    rd(3'd3, s);
    check(s == 16'h0009, "R8 status after arb loss", s, 9);
    check(te >= 0 && te < td, "R8 arb flag before complete", te, td);
    wr(3'd3, 16'h001F);

    // R10 rejected launches
    wr(3'd4, 16'd0); clear_run(); wr(3'd6, 16'h0001); idle(30);
    rd(3'd3, s);
    check(logn == 0 && s == 0, "R10 zero length ignored", logn * 256 + s, 0);
    wr(3'd0, 16'h0010); wr(3'd4, 16'h0003); clear_run(); wr(3'd6, 16'h0001); idle(30);
    rd(3'd3, s);
    check(logn == 0 && s == 0, "R10 zero read length ignored", logn * 256 + s, 0);
    wr(3'd0, 16'h0000); wr(3'd4, 16'd2); wr(3'd5, 16'd0);
    clear_run(); wr(3'd6, 16'h0001); idle(30);
    check(logn == 0, "R10 zero count ignored", logn, 0);

    // R11 launch while busy
    wr(3'd5, 16'd1);
    clear_run(); build_plain(1'b0, 1'b0, 8'hA4, 2, 1);
    wr(3'd6, 16'h0001); idle(4); wr(3'd6, 16'hC001);
    wait_done(te, td);
    cmp_seq("R11 busy launch ignored");
    rd(3'd3, s);
    check(s == 16'h0001, "R11 no auto flag after ignored launch", s, 1);
    wr(3'd3, 16'h001F);

    // R9 auto-restart
    wr(3'd5, 16'd0);
    clear_run();
    wr(3'd6, 16'hC001);
    wait_bit4(); idle(20);
    check(logn == 4, "R9 pause after first transfer", logn, 4);
    rd(3'd3, s);
    check(s == 16'h0010, "R9 transfer flag only", s, 16'h10);
    wr(3'd3, 16'h0010);
    push(3'd1, 8'd0); push(3'd2, 8'hA4); push_data(1'b0, 2);
    push(3'd4, 8'd0); push(3'd2, 8'hA4); push_data(1'b0, 2); push(3'd5, 8'd0);
    wr(3'd6, 16'h0001);
    wait_done(te, td);
    cmp_seq("R9 auto-restart sequence");
    rd(3'd3, s);
    check(s == 16'h0011, "R9 final status", s, 16'h11);
    wr(3'd3, 16'h001F);

    check(hs_err == 0, "R12 command held stable", hs_err, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule